// File: doc/BRIEF.md
# SDRAM Command Sequencer

This block drives the control, mask and address pins of one SDRAM device. It takes commands from two places. A software port requests single commands: mode register load, precharge of every bank, auto refresh, self refresh entry, self refresh exit and burst stop. A bus-master port requests reads and writes, and the block expands each one into a row activate, a column read or write, and a precharge when the master does not ask for auto-precharge.

The length of an access is set only by the block's own counters: the activate-to-column delay (`cfg_trcd`) and the read latency (`cfg_cl3`). No wait-state input exists. A global enable gates everything. While it is low the device is deselected with clock enable high. While it is high, every cycle with nothing to do carries a NOP.

Clock enable is handled over two cycles. Self refresh entry is the refresh pin pattern with clock enable dropping in that same cycle. Clock enable then stays low, and bus requests are held off, until an exit command raises it again.

Top module: `sdram_cmd_issuer`

## Requirements
- R1: In reset, and in every cycle after an edge at which `en` was low, the pins are deselected: `{cke,cs_n,ras_n,cas_n,we_n}` = 11111 and `dqm`=1. `req_ack` and `busy` are 0. Software and bus requests made while `en` is low are dropped.
- R2: With `en` high and nothing to do, the block drives NOP (`cs_n`=0, `ras_n`=`cas_n`=`we_n`=1, `cke`=1).
- R3: A bus request accepted in idle drives activate (`cs_n,ras_n,cas_n,we_n` = 0,0,1,1) at the next edge, with `dqm`=1 and `addr` = `req_row`.
- R4: The column command follows the activate by `cfg_trcd` cycles, where 0 counts as 1. A read is 0,1,0,1 and a write is 0,1,0,0. It is driven with `dqm`=0, `addr[9:0]` = `req_col`, `addr[10]` = `req_ap` and the upper address bits at 0. The cycles in between carry NOP.
- R5: `req_ack` is a one-cycle pulse. For a write it comes in the cycle of the write command. For a read it comes 3 cycles after the read command when `cfg_cl3`=1 and 2 cycles after when it is 0. Before that the block drives NOP.
- R6: With `req_ap`=0, a precharge (0,0,1,0 with `addr[10]`=0) follows in the cycle after the acknowledge. With `req_ap`=1 that cycle is a NOP.
- R7: `sw_cmd` codes and patterns: 1 = mode load (0,0,0,0; `dqm`=1; `addr` = `sw_data` with bit 10 forced to 0); 2 = precharge all (0,0,1,0; `addr`=0x0400); 3 = auto refresh (0,0,0,1; `cke` stays 1); 6 = burst stop (0,1,1,0; `addr`=0). A command sampled in idle is driven at that same edge. Codes 0 and 7 are ignored.
- R8: Code 4 drives the refresh pattern with `cke`=0 after a cycle with `cke`=1. After that `cke` stays 0 with `cs_n`=1. Bus requests are not acknowledged, and every software code except 5 is dropped.
- R9: Code 5 in self refresh drives `cke`=1 with `cs_n`,`ras_n`,`cas_n`,`we_n` all 1. A bus request that was held off then activates at the next edge.
- R10: A software command beats a bus request sampled in the same idle cycle. A software command that arrives during an access is held and driven in the cycle after the sequence ends.
- R11: `busy` is 1 while a software command is held or an access sequence (column delay, read latency, precharge) is in progress, and 0 in idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| en | input | 1 | Global enable |
| cfg_trcd | input | 2 | Activate-to-column delay in clocks (0 acts as 1) |
| cfg_cl3 | input | 1 | Read latency 3 when 1, 2 when 0 |
| sw_valid | input | 1 | Software command request |
| sw_cmd | input | 3 | Software command code |
| sw_data | input | AW | Mode data for the mode load command |
| req_valid | input | 1 | Bus access request, held until acknowledged |
| req_write | input | 1 | 1 = write, 0 = read |
| req_ap | input | 1 | Auto-precharge requested |
| req_row | input | AW | Row address |
| req_col | input | 10 | Column address |
| req_ack | output | 1 | Access completion pulse |
| busy | output | 1 | Command sequence active or software command held |
| sd_cke | output | 1 | Clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_dqm | output | 1 | Data mask |
| sd_addr | output | AW | Address lines |

## Verification
The bench sweeps every activate-to-column delay, including 0, across both read latencies, both directions and both precharge choices. A design that counts the delay off by one, or treats 0 as no delay, would put the column command in the wrong cycle. The bench checks that a software command wins against a bus request arriving in the same cycle, and that a command arriving mid-access waits rather than cutting the sequence short. A design that got the priority wrong would activate first or emit the command between activate and column. In self refresh the bench keeps a bus request pending and sends a stray refresh code. A design that leaked either would raise clock enable or acknowledge the access before the exit command. Finally, it checks that a disabled block emits nothing despite active requests.

// File: rtl/sdram_cmd_issuer.sv
module sdram_cmd_issuer #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [1:0]    cfg_trcd,
  input  logic          cfg_cl3,
  input  logic          sw_valid,
  input  logic [2:0]    sw_cmd,
  input  logic [AW-1:0] sw_data,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          req_ap,
  input  logic [AW-1:0] req_row,
  input  logic [9:0]    req_col,
  output logic          req_ack,
  output logic          busy,
  output logic          sd_cke,
  output logic          sd_cs_n,
  output logic          sd_ras_n,
  output logic          sd_cas_n,
  output logic          sd_we_n,
  output logic          sd_dqm,
  output logic [AW-1:0] sd_addr
);
  typedef enum logic [2:0] {ST_IDLE, ST_RCD, ST_CL, ST_PRE, ST_SREF} st_t;

  localparam logic [2:0] C_MRS = 3'd1, C_PALL = 3'd2, C_REF = 3'd3,
                         C_SRE = 3'd4, C_SRX = 3'd5, C_BST = 3'd6;
  localparam logic [3:0] P_NOP = 4'b0111, P_DES = 4'b1111, P_ACT = 4'b0011,
                         P_RD = 4'b0101, P_WR = 4'b0100, P_PRE = 4'b0010,
                         P_MRS = 4'b0000, P_REF = 4'b0001, P_BST = 4'b0110;
  localparam logic [AW-1:0] A10 = AW'(1) << 10;

  st_t           st;
  logic [1:0]    cnt;
  logic          pend_q, wr_q, ap_q;
  logic [2:0]    pend_code;
  logic [AW-1:0] mode_q;
  logic [9:0]    col_q;
  logic [3:0]    pins;

  wire          sw_ok    = en && sw_valid && !pend_q && sw_cmd != 3'd0 && sw_cmd != 3'd7;
  wire          have_cmd = pend_q || sw_ok;
  wire [2:0]    eff_cmd  = pend_q ? pend_code : sw_cmd;
  wire [AW-1:0] eff_data = pend_q ? mode_q : sw_data;
  wire [AW-1:0] rw_addr  = {{(AW-11){1'b0}}, ap_q, col_q};
  wire          in_seq   = st == ST_RCD || st == ST_CL || st == ST_PRE;

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = pins;
  assign busy = pend_q || in_seq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; cnt <= '0; pend_q <= 1'b0; pend_code <= '0; mode_q <= '0;
      wr_q <= 1'b0; ap_q <= 1'b0; col_q <= '0;
      pins <= P_DES; sd_cke <= 1'b1; sd_dqm <= 1'b1; sd_addr <= '0; req_ack <= 1'b0;
    end else if (!en) begin
      st <= ST_IDLE; pend_q <= 1'b0;
      pins <= P_DES; sd_cke <= 1'b1; sd_dqm <= 1'b1; sd_addr <= '0; req_ack <= 1'b0;
    end else begin
      pins <= P_NOP; sd_dqm <= 1'b1; sd_addr <= '0; req_ack <= 1'b0;
      if (sw_ok && in_seq) begin
        pend_q <= 1'b1; pend_code <= sw_cmd; mode_q <= sw_data;
      end
      case (st)
        ST_IDLE: begin
          if (have_cmd) begin
            pend_q <= 1'b0;
            case (eff_cmd)
              C_MRS:  begin pins <= P_MRS; sd_addr <= eff_data & ~A10; end
              C_PALL: begin pins <= P_PRE; sd_addr <= A10; end
              C_REF:  pins <= P_REF;
              C_SRE:  begin pins <= P_REF; sd_cke <= 1'b0; st <= ST_SREF; end
              C_BST:  pins <= P_BST;
              default: pins <= P_NOP;
            endcase
          end else if (req_valid) begin
            pins <= P_ACT; sd_addr <= req_row;
            cnt <= (cfg_trcd == 2'd0) ? 2'd1 : cfg_trcd;
            wr_q <= req_write; ap_q <= req_ap; col_q <= req_col;
            st <= ST_RCD;
          end
        end
        ST_RCD: begin
          if (cnt == 2'd1) begin
            pins <= wr_q ? P_WR : P_RD; sd_dqm <= 1'b0; sd_addr <= rw_addr;
            if (wr_q) begin
              req_ack <= 1'b1;
              st <= ap_q ? ST_IDLE : ST_PRE;
            end else begin
              cnt <= cfg_cl3 ? 2'd3 : 2'd2;
              st <= ST_CL;
            end
          end else begin
            cnt <= cnt - 2'd1;
          end
        end
        ST_CL: begin
          if (cnt == 2'd1) begin
            req_ack <= 1'b1;
            st <= ap_q ? ST_IDLE : ST_PRE;
          end else begin
            cnt <= cnt - 2'd1;
          end
        end
        ST_PRE: begin
          pins <= P_PRE;
          st <= ST_IDLE;
        end
        default: begin
          pins <= P_DES;
          if (have_cmd) begin
            pend_q <= 1'b0;
            if (eff_cmd == C_SRX) begin
              sd_cke <= 1'b1;
              st <= ST_IDLE;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/sdram_cmd_issuer_chk.sv
module sdram_cmd_issuer_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic req_valid,
  input logic req_ack,
  input logic busy,
  input logic sd_cke,
  input logic sd_cs_n,
  input logic sd_ras_n,
  input logic sd_cas_n,
  input logic sd_we_n,
  input logic sd_dqm
);
  assert_disable_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (sd_cs_n && sd_cke && !req_ack && !busy));

  assert_col_unmasked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!sd_cs_n && sd_ras_n && !sd_cas_n) |-> !sd_dqm);

  assert_read_no_early_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!sd_cs_n && sd_ras_n && !sd_cas_n && sd_we_n) |=> !req_ack);

  assert_ack_has_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |-> $past(req_valid));

  assert_sre_from_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!sd_cs_n && !sd_ras_n && !sd_cas_n && sd_we_n && !sd_cke) |-> $past(sd_cke));

  assert_sref_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!sd_cke && !$past(sd_cke)) |-> (sd_cs_n && !req_ack));

  assert_exit_pattern_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sd_cke) |-> (sd_cs_n && sd_ras_n && sd_cas_n && sd_we_n));

  assert_act_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!sd_cs_n && !sd_ras_n && sd_cas_n && sd_we_n) |-> busy);
endmodule

bind sdram_cmd_issuer sdram_cmd_issuer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .req_valid(req_valid), .req_ack(req_ack),
  .busy(busy), .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
  .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_dqm(sd_dqm)
);

// File: tb/sdram_cmd_issuer_tb.sv
`timescale 1ns/1ps
module sdram_cmd_issuer_tb;
  localparam int AW = 16;
  localparam logic [4:0] K_NOP = 5'b10111, K_DES = 5'b11111, K_ACT = 5'b10011,
                         K_RD = 5'b10101, K_WR = 5'b10100, K_PRE = 5'b10010,
                         K_MRS = 5'b10000, K_REF = 5'b10001, K_SRE = 5'b00001,
                         K_BST = 5'b10110, K_SRX = 5'b11111, K_SRH = 5'b01111;

  logic clk = 0, rst_n = 0, en = 0;
  logic [1:0] cfg_trcd = 0;
  logic cfg_cl3 = 0, sw_valid = 0, req_valid = 0, req_write = 0, req_ap = 0;
  logic [2:0] sw_cmd = 0;
  logic [AW-1:0] sw_data = 0, req_row = 0;
  logic [9:0] req_col = 0;
  logic req_ack, busy, sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dqm;
  logic [AW-1:0] sd_addr;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  sdram_cmd_issuer #(.AW(AW)) u_dut (.*);

  wire [4:0] pv = {sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic sw_issue(input logic [2:0] code, input logic [AW-1:0] data);
    sw_valid = 1; sw_cmd = code; sw_data = data;
    tick;
    sw_valid = 0;
  endtask

  task automatic access(input logic [1:0] t, input logic c3, input logic w, input logic a,
                        input logic [AW-1:0] row, input logic [9:0] col);
    int te, ce;
    cfg_trcd = t; cfg_cl3 = c3;
    req_valid = 1; req_write = w; req_ap = a; req_row = row; req_col = col;
    tick;
    chk("R3", "activate pins", 32'(pv), 32'(K_ACT));
    chk("R3", "activate row", 32'(sd_addr), 32'(row));
    chk("R3", "activate dqm", 32'(sd_dqm), 1);
    chk("R11", "busy in sequence", 32'(busy), 1);
    te = (t == 0) ? 1 : int'(t);
    for (int k = 1; k < te; k++) begin
      tick;
      chk("R4", "nop during trcd", 32'(pv), 32'(K_NOP));
    end
    tick;
    chk("R4", "column pins", 32'(pv), 32'(w ? K_WR : K_RD));
    chk("R4", "column addr", 32'(sd_addr), 32'({5'b0, a, col}));
    chk("R4", "column dqm", 32'(sd_dqm), 0);
    if (w) begin
      chk("R5", "write ack", 32'(req_ack), 1);
    end else begin
      chk("R5", "no ack at read", 32'(req_ack), 0);
      ce = c3 ? 3 : 2;
      for (int k = 1; k < ce; k++) begin
        tick;
        chk("R5", "latency wait", 32'({req_ack, pv}), 32'({1'b0, K_NOP}));
      end
      tick;
      chk("R5", "read ack", 32'(req_ack), 1);
    end
    req_valid = 0;
    tick;
    chk("R5", "ack one cycle", 32'(req_ack), 0);
    if (!a) begin
      chk("R6", "precharge pins", 32'(pv), 32'(K_PRE));
      chk("R6", "precharge a10", 32'(sd_addr[10]), 0);
      tick;
    end
    chk("R6", "nop after access", 32'(pv), 32'(K_NOP));
    chk("R11", "busy clear", 32'(busy), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int idx;
    repeat (3) tick;
    chk("R1", "reset pins", 32'(pv), 32'(K_DES));
    chk("R1", "reset dqm/ack/busy", 32'({sd_dqm, req_ack, busy}), 32'(3'b100));
    rst_n = 1;
    req_valid = 1; sw_valid = 1; sw_cmd = 3'd3;
    for (int k = 0; k < 4; k++) begin
      tick;
      chk("R1", "disabled pins", 32'(pv), 32'(K_DES));
      chk("R1", "disabled ack/busy", 32'({req_ack, busy}), 0);
    end
    req_valid = 0; sw_valid = 0;
    en = 1;
    tick;
    chk("R2", "idle nop", 32'(pv), 32'(K_NOP));
    chk("R1", "dropped while disabled", 32'(busy), 0);

    idx = 0;
    for (int t = 0; t < 4; t++)
      for (int c = 0; c < 2; c++)
        for (int w = 0; w < 2; w++)
          for (int a = 0; a < 2; a++) begin
            access(2'(t), 1'(c), 1'(w), 1'(a), 16'hA5C3 ^ 16'(idx * 16'h1357), 10'(10'h3FF - idx * 29));
            idx++;
          end

    sw_issue(3'd1, 16'hFFFF);
    chk("R7", "mode load pins", 32'(pv), 32'(K_MRS));
    chk("R7", "mode load addr", 32'(sd_addr), 32'(16'hFBFF));
    chk("R7", "mode load dqm", 32'(sd_dqm), 1);
    tick;
    chk("R7", "nop after mode load", 32'(pv), 32'(K_NOP));
    sw_issue(3'd2, 16'h1234);
    chk("R7", "precharge all", 32'({pv, sd_addr}), 32'({K_PRE, 16'h0400}));
    sw_issue(3'd3, 16'h1234);
    chk("R7", "auto refresh", 32'(pv), 32'(K_REF));
    sw_issue(3'd6, 16'hFFFF);
    chk("R7", "burst stop", 32'({pv, sd_addr}), 32'({K_BST, 16'h0000}));
    sw_issue(3'd7, 16'hFFFF);
    chk("R7", "code 7 ignored", 32'({pv, busy}), 32'({K_NOP, 1'b0}));
    sw_issue(3'd0, 16'hFFFF);
    chk("R7", "code 0 ignored", 32'({pv, busy}), 32'({K_NOP, 1'b0}));

    cfg_trcd = 1; req_valid = 1; req_write = 1; req_ap = 1; req_row = 16'h0F0F; req_col = 10'h055;
    sw_issue(3'd3, 16'h0);
    chk("R10", "software first", 32'(pv), 32'(K_REF));
    tick;
    chk("R10", "then activate", 32'({pv, sd_addr}), 32'({K_ACT, 16'h0F0F}));
    tick;
    chk("R10", "write ack", 32'({pv, req_ack}), 32'({K_WR, 1'b1}));
    req_valid = 0;
    tick;
    chk("R10", "nop", 32'(pv), 32'(K_NOP));

    cfg_trcd = 3; req_valid = 1;
    tick;
    chk("R10", "activate", 32'(pv), 32'(K_ACT));
    sw_issue(3'd6, 16'h0);
    chk("R10", "held, nop", 32'(pv), 32'(K_NOP));
    chk("R11", "busy while held", 32'(busy), 1);
    tick;
    chk("R10", "still trcd", 32'(pv), 32'(K_NOP));
    tick;
    chk("R10", "write not preempted", 32'({pv, req_ack}), 32'({K_WR, 1'b1}));
    req_valid = 0;
    tick;
    chk("R10", "held burst stop", 32'(pv), 32'(K_BST));
    chk("R11", "busy after held cmd", 32'(busy), 0);

    cfg_trcd = 1;
    sw_issue(3'd4, 16'h0);
    chk("R8", "self refresh entry", 32'(pv), 32'(K_SRE));
    req_valid = 1;
    for (int k = 0; k < 4; k++) begin
      tick;
      chk("R8", "self refresh hold", 32'({pv, req_ack}), 32'({K_SRH, 1'b0}));
    end
    sw_issue(3'd3, 16'h0);
    chk("R8", "refresh dropped", 32'(pv), 32'(K_SRH));
    tick;
    chk("R8", "still in self refresh", 32'({pv, busy}), 32'({K_SRH, 1'b0}));
    sw_issue(3'd5, 16'h0);
    chk("R9", "exit pattern", 32'(pv), 32'(K_SRX));
    tick;
    chk("R9", "held request activates", 32'(pv), 32'(K_ACT));
    tick;
    chk("R9", "write after exit", 32'({pv, req_ack}), 32'({K_WR, 1'b1}));
    req_valid = 0;
    tick;
    chk("R2", "back to nop", 32'(pv), 32'(K_NOP));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule